// File: doc/BRIEF.md
# Serial BCD to Excess-3 Code Converter

This block turns a decimal digit, presented one bit per clock with the least significant bit first, into its Excess-3 form, which is the digit plus three. The result also comes out least significant bit first. Each output bit appears on `z_out` in the same clock cycle as the input bit it belongs to. The output is Mealy: it is decoded from the stored state and the live input bit, so the converter adds no cycle of latency.

The carry of the serial add lives in the state. Together with the bit position, this reduces to seven states held in a three-bit register. A bit counts only in a cycle where `bit_vld` is high. While the strobe is low the machine holds its state and drives `z_out` low, so the bits of a digit may be spread out with idle cycles between them. Once the fourth bit has been taken, the machine always returns to its start state, and digits can be streamed with no gap between them.

Reset is asynchronous and active low. It forces the start state at once. Its release is synchronised inside the block, so the first bit is taken a few cycles after `rst_n` rises. The bit patterns 1010 to 1111 are not BCD. Their output bits carry no meaning, but each is still taken as a complete four-bit digit.

Top module: `xs3_serial_conv`

## Requirements
- R1: While reset is asserted, and when it is released, the machine is in its start state. The first valid bit after reset is therefore treated as the least significant bit of a digit.
- R2: In the start state, a valid input bit of 0 gives `z_out` = 1 and a valid input bit of 1 gives `z_out` = 0, in that same cycle.
- R3: When the first two valid bits of a digit are 0 and then 0, `z_out` = 1 in the cycle of the second bit.
- R4: For every digit 0 to 9, the four `z_out` bits taken in the four valid-bit cycles form digit+3 in binary. Bit k of the input (k = 0 for the first cycle) is paired with bit k of the result.
- R5: The input bit sequence 0,0,0,0 gives the output bit sequence 1,1,0,0, which is the code 0011.
- R6: In a cycle with `bit_vld` = 0, `z_out` is 0 and the state is not changed. Idle cycles inside a digit, with any value on `x_in`, leave that digit's result unchanged.
- R7: After the fourth valid bit the machine is back in its start state whatever that bit was. A digit whose first bit follows in the very next cycle is converted correctly.
- R8: Asserting reset part-way through a digit abandons that digit. The next valid bit after release starts a new digit.
- R9: A pattern 10 to 15 has undefined output bits but still uses exactly four valid bits. The digit after it is converted correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_vld | input | 1 | High in a cycle where `x_in` carries a digit bit |
| x_in | input | 1 | Serial BCD input, least significant bit first |
| z_out | output | 1 | Serial Excess-3 output, valid in the cycle of the matching input bit, 0 when `bit_vld` is low |

## Verification
Two functions share a single clock edge: taking the fourth bit of one digit together with the jump back to the start state, and taking the first bit of the next digit. Back-to-back streams of all ten digits provoke this, and so do invalid patterns followed directly by a valid digit. The first `z_out` bit of each following digit shows whether the start state was reached in time. Idle gaps are placed inside digits while `x_in` toggles, to show that the strobe gating and the state hold do not disturb the conversion. Reset part-way through a digit tests whether the partial digit is dropped.

// File: rtl/xs3_serial_pkg.sv
package xs3_serial_pkg;

  localparam int unsigned ST_W = 3;

  // Bit position and pending carry share one encoding.
  // Each name gives the next bit index and whether a carry is pending.
  typedef enum logic [ST_W-1:0] {
    S_T0    = 3'b000,
    S_T1_NC = 3'b001,
    S_T1_CY = 3'b011,
    S_T2_NC = 3'b010,
    S_T2_CY = 3'b110,
    S_T3_NC = 3'b100,
    S_T3_CY = 3'b101
  } xs3_state_e;

endpackage

// File: rtl/xs3_rst_sync.sv
module xs3_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;

  initial begin
    if (STAGES < 2) $error("xs3_rst_sync needs at least two stages");
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ok = sync_q[LAST];

endmodule

// File: rtl/xs3_step_logic.sv
module xs3_step_logic
  import xs3_serial_pkg::*;
(
  input  xs3_state_e cur,
  input  logic       vld,
  input  logic       x,
  output xs3_state_e nxt,
  output logic       z
);

  logic z_raw;

  // Serial add of the constant 0011: the addend bits are 1,1,0,0 from t0 to t3.
  always_comb begin
    z_raw = 1'b0;
    nxt   = S_T0;
    case (cur)
      S_T0: begin            // x + 1
        z_raw = ~x;
        nxt   = x ? S_T1_CY : S_T1_NC;
      end
      S_T1_NC: begin         // x + 1
        z_raw = ~x;
        nxt   = x ? S_T2_CY : S_T2_NC;
      end
      S_T1_CY: begin         // x + 1 + 1, carry always out
        z_raw = x;
        nxt   = S_T2_CY;
      end
      S_T2_NC: begin         // x + 0
        z_raw = x;
        nxt   = S_T3_NC;
      end
      S_T2_CY: begin         // x + carry
        z_raw = ~x;
        nxt   = x ? S_T3_CY : S_T3_NC;
      end
      S_T3_NC: begin         // last bit, wrap
        z_raw = x;
        nxt   = S_T0;
      end
      S_T3_CY: begin         // last bit with carry; x = 1 only for non-BCD input
        z_raw = ~x;
        nxt   = S_T0;
      end
      default: begin
        z_raw = 1'b0;
        nxt   = S_T0;
      end
    endcase
  end

  assign z = vld & z_raw;

endmodule

// File: rtl/xs3_state_reg.sv
module xs3_state_reg
  import xs3_serial_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ok,
  input  logic       en,
  input  xs3_state_e d,
  output xs3_state_e q
);

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)  q <= S_T0;
    else if (en)  q <= d;
  end

  // R4: only the seven reduced states are ever stored
  p_legal_state_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    q inside {S_T0, S_T1_NC, S_T1_CY, S_T2_NC, S_T2_CY, S_T3_NC, S_T3_CY});

endmodule

// File: rtl/xs3_serial_conv.sv
module xs3_serial_conv
  import xs3_serial_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic x_in,
  output logic z_out
);

  logic       rst_ok;
  xs3_state_e cur_st;
  xs3_state_e nxt_st;

  xs3_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  xs3_step_logic u_step (
    .cur (cur_st),
    .vld (bit_vld),
    .x   (x_in),
    .nxt (nxt_st),
    .z   (z_out)
  );

  xs3_state_reg u_state (
    .clk    (clk),
    .rst_ok (rst_ok),
    .en     (bit_vld),
    .d      (nxt_st),
    .q      (cur_st)
  );

  // R1: the state is the start state on the cycle the internal reset lifts
  p_start_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_ok) |-> cur_st == S_T0);

  // R2: a zero in the first bit position yields a one
  p_first_zero_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (cur_st == S_T0 && bit_vld && !x_in) |-> z_out);

  // R3: zero, zero gives a one at the second bit
  p_second_zero_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (cur_st == S_T1_NC && bit_vld && !x_in) |-> z_out);

  // R6: no output while the strobe is low
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    !bit_vld |-> !z_out);

  // R6: no state movement while the strobe is low
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    !bit_vld |=> cur_st == $past(cur_st));

  // R7: the fourth valid bit always wraps to the start
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (bit_vld && (cur_st == S_T3_NC || cur_st == S_T3_CY)) |=> cur_st == S_T0);

endmodule

// File: tb/xs3_serial_conv_bench.sv
module xs3_serial_conv_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0;
  logic x_in = 1'b0;
  logic z_out;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  xs3_serial_conv u_xs3_serial_conv (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (bit_vld),
    .x_in    (x_in),
    .z_out   (z_out)
  );

  task automatic chk1(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic chk4(input logic [3:0] act, input logic [3:0] exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic idle(input int n, input bit wiggle);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_vld = 1'b0;
      x_in    = wiggle ? ~x_in : 1'b0;
      #1 chk1(z_out, 1'b0, "R6", "z_out during idle");
    end
  endtask

  task automatic send_bit(input logic b, output logic z);
    @(negedge clk);
    bit_vld = 1'b1;
    x_in    = b;
    #1 z = z_out;
  endtask

  task automatic send_digit(input logic [3:0] d, input int gap, output logic [3:0] zc);
    for (int i = 0; i < 4; i++) begin
      send_bit(d[i], zc[i]);
      if (gap > 0 && i < 3) idle(gap, 1'b1);
    end
  endtask

  task automatic t_reset();
    logic z;
    @(negedge clk);
    bit_vld = 1'b0;
    #1 chk1(z_out, 1'b0, "R1", "z_out in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(4, 1'b0);
    send_bit(1'b0, z);
    chk1(z, 1'b1, "R1", "first bit after reset is t0");
    send_bit(1'b0, z);
    send_bit(1'b0, z);
    send_bit(1'b0, z);
    idle(1, 1'b0);
  endtask

  task automatic t_first_bits();
    logic [3:0] zc;
    send_digit(4'd0, 0, zc);
    chk1(zc[0], 1'b1, "R2", "t0 input 0");
    chk1(zc[1], 1'b1, "R3", "t1 after 0,0");
    chk4(zc, 4'b0011, "R5", "digit 0 code");
    send_digit(4'd1, 0, zc);
    chk1(zc[0], 1'b0, "R2", "t0 input 1");
    chk4(zc, 4'd4, "R4", "digit 1 code");
    idle(2, 1'b0);
  endtask

  task automatic t_stream();
    logic [3:0] zc;
    for (int d = 0; d < 10; d++) begin
      send_digit(4'(d), 0, zc);
      chk4(zc, 4'(d + 3), "R7", $sformatf("back-to-back digit %0d", d));
    end
    for (int d = 9; d >= 0; d--) begin
      send_digit(4'(d), 0, zc);
      chk4(zc, 4'(d + 3), "R4", $sformatf("descending digit %0d", d));
    end
    idle(2, 1'b0);
  endtask

  task automatic t_gaps();
    logic [3:0] zc;
    for (int d = 0; d < 10; d++) begin
      send_digit(4'(d), (d % 3) + 1, zc);
      chk4(zc, 4'(d + 3), "R6", $sformatf("digit %0d with idle gaps", d));
      idle(1, 1'b1);
    end
  endtask

  task automatic t_mid_reset();
    logic       z;
    logic [3:0] zc;
    send_bit(1'b1, z);
    send_bit(1'b1, z);
    @(negedge clk);
    rst_n   = 1'b0;
    bit_vld = 1'b0;
    #1 chk1(z_out, 1'b0, "R8", "z_out in reset mid-digit");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(4, 1'b0);
    send_digit(4'd6, 0, zc);
    chk4(zc, 4'd9, "R8", "digit after aborted digit");
    idle(1, 1'b0);
  endtask

  task automatic t_invalid();
    logic [3:0] zc;
    for (int d = 10; d < 16; d++) begin
      send_digit(4'(d), 0, zc);
      send_digit(4'(d - 8), 0, zc);
      chk4(zc, 4'(d - 5), "R9", $sformatf("valid digit after pattern %0d", d));
    end
    idle(2, 1'b0);
  endtask

  initial begin
    t_reset();
    t_first_bits();
    t_stream();
    t_gaps();
    t_mid_reset();
    t_invalid();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1600000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule